// File: doc/BRIEF.md
# SDR SDRAM Controller with Periodic Refresh

This block drives a single-rank, 64-bit SDR SDRAM built from four x16 devices with four internal banks, 13 row bits, 9 column bits and 2 bank bits. After reset it runs the power-up sequence: a long quiet period, a precharge of all banks, eight auto refreshes, and a mode register write. It then serves one user access at a time. Every access opens a row, issues a single-beat READ or WRITE with auto-precharge, and waits until the bank is closed again. All nanosecond limits are turned into clock counts by rounding up at elaboration time.

The user side has one request stream. `req_valid`/`req_ready` follow the usual rule: a request is taken on a rising edge where both are high, and the requester must hold every request field stable while `req_valid` is high and `req_ready` is low. `req_ready` is low during initialisation, during every access and its closing window, and whenever a refresh is owed. Read data comes back on `rd_valid`/`rd_data` with no back-pressure: the consumer must take each beat in the cycle it is shown. A periodic timer raises a refresh request, and that refresh always goes ahead of the next user access.

The SDRAM side is modelled as registered pins: command strobes, bank, address, byte mask, and a split data bus (`sd_dq_out`, `sd_dq_oe`, `sd_dq_in`).

Top module: `sdrc_top`

## Requirements
- R1: While reset is asserted and for at least ceil(INIT_NS/TCK_NS) cycles after it (40000 at defaults), `sd_cke` is 1, `sd_dqm` is all ones, the command is NOP and `req_ready` is 0.
- R2: Initialisation issues exactly this order: PRECHARGE with A10=1, then 8 AUTO REFRESH, then MODE REGISTER SET with A[2:0]=000 (burst length 1), A3=0 (sequential), A[6:4]=CAS latency and all other address bits 0. No ACTIVE is issued earlier than 2 cycles after the MODE REGISTER SET.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE REGISTER SET 0000. A user write gives WRITE and a user read gives READ.
- R4: The user address splits as bank = addr[23:22], row = addr[21:9], column = addr[8:0]. ACTIVE drives the bank on BA and the row on A[12:0]. READ/WRITE drive the same bank, the column on A[8:0], A10=1 (auto-precharge) and A12/A11=0.
- R5: READ or WRITE appears exactly ceil(tRCD/tCK) cycles after its ACTIVE (4 at defaults).
- R6: An ACTIVE or AUTO REFRESH appears no sooner than max(tRC, tRAS+tRP, tRCD+access close time) cycles after the previous ACTIVE (13 at defaults). Consecutive AUTO REFRESH commands are at least ceil(tRFC/tCK) = 12 cycles apart, and the first refresh comes at least ceil(tRP/tCK) = 4 cycles after the PRECHARGE.
- R7: In the WRITE cycle, `sd_dq_oe`=1, `sd_dq_out`=`req_wdata` and `sd_dqm`=~`req_wbe` (zero-latency mask, a set `req_wbe` bit writes that byte). `sd_dq_oe` is 0 in all other cycles.
- R8: After initialisation, `sd_dqm` is 0 in every cycle except a WRITE cycle, so read bytes are enabled two cycles before their data. `rd_valid` pulses for one cycle, CAS_LAT+1 cycles after the READ command appears, and `rd_data` then holds `sd_dq_in` as sampled CAS_LAT cycles after the READ.
- R9: After initialisation, a refresh falls due every floor(REFI_NS/TCK_NS) cycles (1560 at defaults). The AUTO REFRESH is issued within 20 cycles of falling due, before any new ACTIVE.
- R10: `req_ready` is 1 only while no command is in progress, and in those cycles the command pins show NOP. Each handshake gives exactly one ACTIVE and one READ or WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address {bank, row, column} |
| req_wdata | input | 64 | Write data |
| req_wbe | input | 8 | Byte enables for writes, 1 = write byte |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 64 | Read beat data |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 8 | Byte mask, high = masked |
| sd_dq_out | output | 64 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Data drive enable |
| sd_dq_in | input | 64 | Data returned by the memory |

## Verification
Each result has a fixed place in time. The first PRECHARGE is due no sooner than 40000 cycles after reset release. READ/WRITE come exactly 4 cycles after their ACTIVE. The next ACTIVE or REFRESH comes no sooner than 13 cycles after an ACTIVE. A read beat shows on `rd_valid` exactly CAS_LAT+1 cycles after the READ, and a refresh is issued within 20 cycles of each 1560-cycle tick. The bench counts rising edges and looks at every pin on the falling edge. It records the cycle of each command it sees and compares the differences against those numbers. Its memory model drives `sd_dq_in` only in the single cycle CAS_LAT after a READ, and applies the mask seen two cycles earlier, so a beat captured one cycle early or late, or a read mask left high, returns wrong data.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_PREALL,
    ST_INITREF,
    ST_MRS,
    ST_IDLE,
    ST_RW,
    ST_WAIT
  } seq_st_e;

  function automatic int ceil_cyc(input int t_ns, input int tck_ns);
    return (t_ns + tck_ns - 1) / tck_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // counter load for a command-to-command distance of n cycles through ST_WAIT
  function automatic int wait_load(input int n);
    return (n < 2) ? 0 : n - 2;
  endfunction

endpackage

// File: rtl/sdrc_refresh_timer.sv
module sdrc_refresh_timer #(
  parameter int REFI_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int W = $clog2(REFI_CYC + 1);
  localparam logic [W-1:0] LAST = W'(REFI_CYC - 1);

  logic [W-1:0] tick_q;
  logic         wrap;

  assign wrap = run && (tick_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      pending <= 1'b0;
    end else begin
      if (run) tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdrc_read_pipe.sv
module sdrc_read_pipe #(
  parameter int CAS_LAT = 3,
  parameter int DQ_W    = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  logic [CAS_LAT-1:0] flight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flight_q <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      flight_q <= {flight_q[CAS_LAT-2:0], rd_issue};
      rd_valid <= flight_q[CAS_LAT-1];
      if (flight_q[CAS_LAT-1]) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdrc_seq.sv
module sdrc_seq
  import sdrc_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 64,
  parameter int CAS_LAT   = 3,
  parameter int INIT_CYC  = 40000,
  parameter int INIT_REFS = 8,
  parameter int TRCD_C    = 4,
  parameter int TRP_C     = 4,
  parameter int TRFC_C    = 12,
  parameter int TMRD_C    = 2,
  parameter int GAP_RD_C  = 13,
  parameter int GAP_WR_C  = 13,
  localparam int ADDR_W   = BA_W + ROW_W + COL_W,
  localparam int BE_W     = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [BE_W-1:0]   req_wbe,
  input  logic              ref_pending,
  output logic              ref_ack,
  output logic              init_done,
  output sd_cmd_e           cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ROW_W-1:0]  a,
  output logic [BE_W-1:0]   dqm,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe
);
  localparam int AP_BIT = 10;
  localparam int CNT_W  = $clog2(imax(INIT_CYC, 64) + 1);
  localparam int REF_W  = $clog2(INIT_REFS + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;

  seq_st_e            state_q, ret_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [REF_W-1:0]   refs_left_q;
  logic               lat_write_q;
  logic [BA_W-1:0]    lat_ba_q;
  logic [COL_W-1:0]   lat_col_q;
  logic [DQ_W-1:0]    lat_data_q;
  logic [BE_W-1:0]    lat_be_q;

  logic [BA_W-1:0]    in_ba;
  logic [ROW_W-1:0]   in_row;
  logic [COL_W-1:0]   in_col;

  assign in_ba     = req_addr[ADDR_W-1 -: BA_W];
  assign in_row    = req_addr[COL_W +: ROW_W];
  assign in_col    = req_addr[COL_W-1:0];
  assign req_ready = (state_q == ST_IDLE) && !ref_pending;
  assign ref_ack   = (state_q == ST_IDLE) && ref_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_POWERUP;
      ret_q       <= ST_IDLE;
      cnt_q       <= CNT_W'(INIT_CYC - 1);
      refs_left_q <= '0;
      init_done   <= 1'b0;
      cmd         <= CMD_NOP;
      ba          <= '0;
      a           <= '0;
      dqm         <= '1;
      dq_out      <= '0;
      dq_oe       <= 1'b0;
      lat_write_q <= 1'b0;
      lat_ba_q    <= '0;
      lat_col_q   <= '0;
      lat_data_q  <= '0;
      lat_be_q    <= '0;
    end else begin
      cmd   <= CMD_NOP;
      dq_oe <= 1'b0;
      dqm   <= init_done ? '0 : '1;
      unique case (state_q)
        ST_POWERUP: begin
          if (cnt_q == '0) state_q <= ST_PREALL;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_PREALL: begin
          cmd         <= CMD_PRE;
          a           <= AP_MASK;
          refs_left_q <= REF_W'(INIT_REFS);
          cnt_q       <= CNT_W'(wait_load(TRP_C));
          ret_q       <= ST_INITREF;
          state_q     <= ST_WAIT;
        end
        ST_INITREF: begin
          cmd         <= CMD_REF;
          refs_left_q <= refs_left_q - 1'b1;
          cnt_q       <= CNT_W'(wait_load(TRFC_C));
          ret_q       <= (refs_left_q == REF_W'(1)) ? ST_MRS : ST_INITREF;
          state_q     <= ST_WAIT;
        end
        ST_MRS: begin
          cmd       <= CMD_MRS;
          a         <= MODE_WORD;
          ba        <= '0;
          init_done <= 1'b1;
          cnt_q     <= CNT_W'(wait_load(TMRD_C));
          ret_q     <= ST_IDLE;
          state_q   <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            cmd     <= CMD_REF;
            cnt_q   <= CNT_W'(wait_load(TRFC_C));
            ret_q   <= ST_IDLE;
            state_q <= ST_WAIT;
          end else if (req_valid) begin
            cmd         <= CMD_ACT;
            ba          <= in_ba;
            a           <= in_row;
            lat_write_q <= req_write;
            lat_ba_q    <= in_ba;
            lat_col_q   <= in_col;
            lat_data_q  <= req_wdata;
            lat_be_q    <= req_wbe;
            cnt_q       <= CNT_W'(wait_load(TRCD_C));
            ret_q       <= ST_RW;
            state_q     <= ST_WAIT;
          end
        end
        ST_RW: begin
          cmd     <= lat_write_q ? CMD_WR : CMD_RD;
          ba      <= lat_ba_q;
          a       <= ROW_W'(lat_col_q) | AP_MASK;
          ret_q   <= ST_IDLE;
          state_q <= ST_WAIT;
          if (lat_write_q) begin
            dq_oe  <= 1'b1;
            dq_out <= lat_data_q;
            dqm    <= ~lat_be_q;
            cnt_q  <= CNT_W'(wait_load(GAP_WR_C - TRCD_C));
          end else begin
            cnt_q  <= CNT_W'(wait_load(GAP_RD_C - TRCD_C));
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ret_q;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdrc_top.sv
module sdrc_top
  import sdrc_pkg::*;
#(
  parameter int TCK_NS    = 5,
  parameter int CAS_LAT   = 3,
  parameter int INIT_NS   = 200000,
  parameter int REFI_NS   = 7800,
  parameter int TRCD_NS   = 20,
  parameter int TRP_NS    = 20,
  parameter int TRAS_NS   = 45,
  parameter int TRC_NS    = 60,
  parameter int TRFC_NS   = 60,
  parameter int TWR_NS    = 15,
  parameter int TDAL_MIN  = 5,
  parameter int INIT_REFS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic [63:0] req_wdata,
  input  logic [7:0]  req_wbe,
  output logic        rd_valid,
  output logic [63:0] rd_data,
  output logic        sd_cke,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [12:0] sd_a,
  output logic [7:0]  sd_dqm,
  output logic [63:0] sd_dq_out,
  output logic        sd_dq_oe,
  input  logic [63:0] sd_dq_in
);
  localparam int INIT_CYC = ceil_cyc(INIT_NS, TCK_NS);
  localparam int REFI_CYC = REFI_NS / TCK_NS;
  localparam int TRCD_C   = ceil_cyc(TRCD_NS, TCK_NS);
  localparam int TRP_C    = ceil_cyc(TRP_NS, TCK_NS);
  localparam int TRAS_C   = ceil_cyc(TRAS_NS, TCK_NS);
  localparam int TRC_C    = ceil_cyc(TRC_NS, TCK_NS);
  localparam int TRFC_C   = ceil_cyc(TRFC_NS, TCK_NS);
  localparam int TWR_C    = ceil_cyc(TWR_NS, TCK_NS);
  localparam int TDAL_C   = imax(TDAL_MIN, TWR_C + TRP_C);
  localparam int CLOSE_C  = imax(TRC_C, TRAS_C + TRP_C);
  localparam int GAP_RD_C = imax(CLOSE_C, TRCD_C + 1 + TRP_C);
  localparam int GAP_WR_C = imax(CLOSE_C, TRCD_C + TDAL_C);
  localparam int GAP_MIN  = (GAP_RD_C < GAP_WR_C) ? GAP_RD_C : GAP_WR_C;

  sd_cmd_e cmd;
  logic    ref_pending, ref_ack, init_done;

  assign sd_cke = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  sdrc_refresh_timer #(.REFI_CYC(REFI_CYC)) refresh_i (
    .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdrc_seq #(
    .BA_W(2), .ROW_W(13), .COL_W(9), .DQ_W(64), .CAS_LAT(CAS_LAT),
    .INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS), .TRCD_C(TRCD_C), .TRP_C(TRP_C),
    .TRFC_C(TRFC_C), .TMRD_C(2), .GAP_RD_C(GAP_RD_C), .GAP_WR_C(GAP_WR_C)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wbe(req_wbe),
    .ref_pending(ref_pending), .ref_ack(ref_ack), .init_done(init_done),
    .cmd(cmd), .ba(sd_ba), .a(sd_a), .dqm(sd_dqm),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe)
  );

  sdrc_read_pipe #(.CAS_LAT(CAS_LAT), .DQ_W(64)) rdpipe_i (
    .clk(clk), .rst_n(rst_n), .rd_issue(cmd == CMD_RD),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/sdrc_checker.sv
module sdrc_checker #(
  parameter int CAS_LAT = 3,
  parameter int TRCD    = 4,
  parameter int GAP     = 13
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sd_cs_n,
  input logic        sd_ras_n,
  input logic        sd_cas_n,
  input logic        sd_we_n,
  input logic [12:0] sd_a,
  input logic        sd_dq_oe,
  input logic        rd_valid,
  input logic        req_ready
);
  logic [3:0] pin_cmd;
  logic       is_act, is_ref, is_rd, is_wr, is_nop;
  logic [7:0] since_act_q;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act  = (pin_cmd == 4'b0011);
  assign is_ref  = (pin_cmd == 4'b0001);
  assign is_rd   = (pin_cmd == 4'b0101);
  assign is_wr   = (pin_cmd == 4'b0100);
  assign is_nop  = (pin_cmd == 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_act_q <= 8'hFF;
    else if (is_act)            since_act_q <= 8'd1;
    else if (since_act_q != 8'hFF) since_act_q <= since_act_q + 8'd1;
  end

  AST_AP_ON_ACCESS:  assert property (@(posedge clk) disable iff (!rst_n) (is_rd || is_wr) |-> sd_a[10]); // R4
  AST_RCD_EXACT:     assert property (@(posedge clk) disable iff (!rst_n) (is_rd || is_wr) |-> (since_act_q == 8'(TRCD))); // R5
  AST_ROW_GAP:       assert property (@(posedge clk) disable iff (!rst_n) (is_act || is_ref) |-> (since_act_q >= 8'(GAP))); // R6
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) sd_dq_oe |-> is_wr); // R7
  AST_RDV_LATENCY:   assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(is_rd, CAS_LAT + 1)); // R8
  AST_READY_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> is_nop); // R10
endmodule

bind sdrc_top sdrc_checker #(.CAS_LAT(CAS_LAT), .TRCD(TRCD_C), .GAP(GAP_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a(sd_a), .sd_dq_oe(sd_dq_oe),
  .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/sdrc_top_tb_top.sv
`timescale 1ns/1ps
module sdrc_top_tb_top;
  localparam int CL       = 3;
  localparam int INIT_CYC = 40000;
  localparam int REFI     = 1560;
  localparam int RCD      = 4;
  localparam int GAP      = 13;
  localparam int RFC      = 12;
  localparam int RP       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_wbe = '0;
  logic req_ready, rd_valid;
  logic [63:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [12:0] sd_a;
  logic [7:0] sd_dqm;
  logic [63:0] sd_dq_out;
  logic [63:0] sd_dq_in = 64'hBAD0_BAD0_BAD0_BAD0;

  sdrc_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_wbe(req_wbe),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // bench-side expectations
  logic [63:0] exp_mem [128];
  logic [63:0] sdram   [128];
  logic [12:0] open_row [4];
  logic [23:0] cur_addr;
  logic [63:0] cur_data, rd_exp;
  logic [7:0]  cur_be;
  logic        cur_write;
  bit op_busy = 0;
  bit ready_early = 0;

  function automatic logic [6:0] idx_of(input logic [23:0] ad);
    return {ad[23:22], ad[10:9], ad[2:0]};
  endfunction
  function automatic logic [23:0] mk_addr(input int b, input int r, input int c);
    logic [12:0] row; logic [8:0] col;
    row = (r < 2) ? 13'(r) : (13'h1FFC | 13'(r));
    col = 9'(c) | ((c >= 4) ? 9'h1F8 : 9'h000);
    return {2'(b), row, col};
  endfunction
  function automatic logic [63:0] pat(input logic [23:0] ad);
    return {8'hA5, ad, 8'h3C, ~ad};
  endfunction

  // monitor and memory model, sampled on falling edges
  int stage = 0, init_refs = 0, post_refs = 0;
  int last_act = -1000, last_ref = -1000, last_pre = -1000, mrs_cyc = 0, prev_ref_post = 0;
  int rd_cyc = -1000;
  bit rd_wait = 0;
  logic [7:0] rd_dqm_seen;
  logic [3:0] pc;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (stage < 2 && req_ready) ready_early = 1;
      if (stage < 2) chk(sd_cke == 1'b1, "R1 cke high during init", 64'(sd_cke), 64'h1);
      if (sd_dq_oe && pc != 4'b0100) chk(0, "R7 dq_oe outside WRITE", 64'(pc), 64'h4);
      if (stage == 2 && pc != 4'b0100 && cyc > mrs_cyc) chk(sd_dqm == 8'h00, "R8 dqm low outside WRITE", 64'(sd_dqm), 64'h0);
      case (pc)
        4'b0111: ;
        4'b0010: begin
          chk(stage == 0, "R2 precharge only at start", 64'(stage), 64'h0);
          chk(sd_a[10] == 1'b1, "R2 precharge all A10", 64'(sd_a[10]), 64'h1);
          chk(cyc >= INIT_CYC, "R1 quiet period length", 64'(cyc), 64'(INIT_CYC));
          last_pre = cyc; stage = 1;
        end
        4'b0001: begin
          chk(cyc - last_pre >= RP, "R6 tRP before refresh", 64'(cyc - last_pre), 64'(RP));
          chk(cyc - last_ref >= RFC, "R6 tRFC between refreshes", 64'(cyc - last_ref), 64'(RFC));
          chk(cyc - last_act >= GAP, "R6 gap ACT to REF", 64'(cyc - last_act), 64'(GAP));
          if (stage == 1) init_refs++;
          else begin
            chk((cyc - prev_ref_post >= REFI - 20) && (cyc - prev_ref_post <= REFI + 20),
                "R9 refresh interval", 64'(cyc - prev_ref_post), 64'(REFI));
            prev_ref_post = cyc; post_refs++;
          end
          last_ref = cyc;
        end
        4'b0000: begin
          chk(stage == 1 && init_refs == 8, "R2 eight refreshes before MRS", 64'(init_refs), 64'd8);
          chk(sd_a == 13'(CL << 4), "R2 mode word", 64'(sd_a), 64'(CL << 4));
          stage = 2; mrs_cyc = cyc; prev_ref_post = cyc;
        end
        4'b0011: begin
          chk(stage == 2 && cyc - mrs_cyc >= 2, "R2 ACT after MRS", 64'(cyc - mrs_cyc), 64'd2);
          chk({sd_ba, sd_a} == cur_addr[23:9], "R4 ACT bank/row", 64'({sd_ba, sd_a}), 64'(cur_addr[23:9]));
          chk(cyc - last_act >= GAP, "R6 ACT to ACT gap", 64'(cyc - last_act), 64'(GAP));
          chk(cyc - last_ref >= RFC, "R6 REF to ACT gap", 64'(cyc - last_ref), 64'(RFC));
          open_row[sd_ba] = sd_a; last_act = cyc;
        end
        4'b0100, 4'b0101: begin
          chk((pc == 4'b0100) == cur_write, "R3 access type", 64'(pc), 64'(cur_write ? 4 : 5));
          chk(cyc - last_act == RCD, "R5 tRCD", 64'(cyc - last_act), 64'(RCD));
          chk({sd_ba, sd_a[12:11], sd_a[10], sd_a[8:0]} == {cur_addr[23:22], 2'b00, 1'b1, cur_addr[8:0]},
              "R4 column/bank/auto-precharge", 64'(sd_a), 64'(cur_addr[8:0]));
          if (pc == 4'b0100) begin
            chk(sd_dq_oe && sd_dq_out == cur_data, "R7 write data", sd_dq_out, cur_data);
            chk(sd_dqm == ~cur_be, "R7 write mask", 64'(sd_dqm), 64'(~cur_be));
            for (int k = 0; k < 8; k++)
              if (!sd_dqm[k]) sdram[{sd_ba, open_row[sd_ba][1:0], sd_a[2:0]}][8*k +: 8] = sd_dq_out[8*k +: 8];
            op_busy = 0;
          end else begin
            rd_cyc = cyc; rd_wait = 1;
          end
        end
        default: chk(0, "R3 unknown command", 64'(pc), 64'h7);
      endcase
      if (cyc == rd_cyc + CL - 2) rd_dqm_seen = sd_dqm;
      sd_dq_in = 64'hBAD0_BAD0_BAD0_BAD0;
      if (cyc == rd_cyc + CL) begin
        sd_dq_in = sdram[idx_of(cur_addr)];
        for (int k = 0; k < 8; k++) if (rd_dqm_seen[k]) sd_dq_in[8*k +: 8] = 8'h00;
      end
      if (rd_valid) begin
        chk(rd_wait && cyc == rd_cyc + CL + 1, "R8 read latency", 64'(cyc - rd_cyc), 64'(CL + 1));
        chk(rd_data == rd_exp, "R8 read data", rd_data, rd_exp);
        rd_wait = 0; op_busy = 0;
      end
    end
  end

  task automatic do_req(input logic w, input logic [23:0] ad, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = ad; req_wdata = d; req_wbe = be;
    cur_write = w; cur_addr = ad; cur_data = d; cur_be = be;
    rd_exp = exp_mem[idx_of(ad)];
    op_busy = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (op_busy) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R10 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] ad;
    logic [63:0] nd;
    logic [7:0]  be;
    repeat (4) @(negedge clk);
    // R1: state held in reset
    chk(sd_cke == 1'b1, "R1 reset cke", 64'(sd_cke), 64'h1);
    chk(sd_dqm == 8'hFF, "R1 reset dqm", 64'(sd_dqm), 64'hFF);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset NOP",
        64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'h7);
    chk(req_ready == 1'b0, "R1 reset not ready", 64'(req_ready), 64'h0);
    rst_n = 1;
    // full writes across all banks, rows and columns of the sweep
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 8; c++) begin
          ad = mk_addr(b, r, c);
          exp_mem[idx_of(ad)] = pat(ad);
          do_req(1'b1, ad, pat(ad), 8'hFF);
        end
    chk(!ready_early, "R1 ready low during init", 64'(ready_early), 64'h0);
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 8; c++) do_req(1'b0, mk_addr(b, r, c), '0, '0);
    // partial writes with single, inverse, empty and mixed byte enables
    for (int i = 0; i < 32; i++) begin
      ad = mk_addr(i % 4, (i / 4) % 4, i % 8);
      be = (i < 8) ? 8'(1 << i) : (i < 16) ? ~8'(1 << (i - 8)) : (i < 24) ? 8'h00 : (8'hA5 ^ 8'(i));
      nd = ~pat(ad);
      for (int k = 0; k < 8; k++) if (be[k]) exp_mem[idx_of(ad)][8*k +: 8] = nd[8*k +: 8];
      do_req(1'b1, ad, nd, be);
      do_req(1'b0, ad, '0, '0);
    end
    // idle stretch so refresh runs with no traffic
    repeat (3500) @(negedge clk);
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 8; c++) do_req(1'b0, mk_addr(b, r, c), '0, '0);
    chk(post_refs >= 4, "R9 refreshes issued", 64'(post_refs), 64'd4);
    repeat (10) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule